// File: doc/BRIEF.md
# Tagged Transmit Byte FIFO

This block is the buffer between a host that writes outgoing bytes and a serial framer that consumes them. It holds up to 19 entries. Each entry is a data byte with two tag bits. The end-of-packet tag marks the last byte of a frame. The abort tag tells the framer to send an abort in place of that byte. The host writes a byte and its end-of-packet tag in one strobe. It arms the abort tag in advance with a control strobe, and that armed state clears itself once a byte has been stored. The framer pops one entry at a time and receives the byte, both tags and an indication when nothing was there.

The host sees the fill level, full, empty and low-water flags through a deliberately slow view. The view catches up with the true occupancy only on the second serial bit tick after the most recent accepted push or pop. This reproduces the status lag of a design whose serial side runs on a slower bit clock. When the view reaches the low-water mark, a level interrupt is raised and held until the host clears it. Writes that find the buffer full are dropped and leave a sticky overflow flag.

Top module: `tx_tag_fifo`

## Requirements
- R1: The buffer holds 19 entries. A write while the true occupancy is 19 is dropped, even if a pop happens in the same cycle, and sets `ovf_flag`. `ovf_flag` stays set until reset.
- R2: Pops return entries in write order. A pop accepted in cycle t gives `rd_valid`=1 with `rd_data` and `rd_eop` in cycle t+1. `rd_eop` equals the `wr_eop` given with that byte.
- R3: A `ctl_wr` strobe with `ctl_abort_arm`=1 sets `abort_armed`. The next accepted write stores abort tag 1 and clears `abort_armed`. That tag comes back as `rd_abort`. An arm strobe in the same cycle as an accepted write applies to the following byte, and a dropped write leaves the armed state in place.
- R4: `stat_level` tracks the true occupancy only with a lag. An accepted push or pop restarts a two-tick countdown. The view is loaded from the occupancy at the clock edge on which the second `bit_tick` after the last access is sampled. It changes at no other time.
- R5: The status flags follow the view. `stat_full` = (view == 19). `stat_empty` = (view == 0). `stat_low` = (view <= 4).
- R6: `irq` is set when the view is loaded with exactly 4 while it held another value. `irq` stays set until a `ctl_wr` strobe with `ctl_irq_clr`=1. A set in the same cycle as a clear wins.
- R7: A pop while the true occupancy is 0 gives `rd_none`=1 and `rd_valid`=0 in the next cycle. Such a pop moves no pointer and does not restart the status countdown.
- R8: A push and a pop accepted in the same cycle both take effect. The occupancy is unchanged and order is kept.
- R9: With `rst_n` low at a clock edge, the block empties. The view, `irq`, `ovf_flag`, `abort_armed`, `rd_valid`, `rd_none` and the read outputs all go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| wr_en | input | 1 | Host byte write |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | End-of-packet tag for this byte |
| ctl_wr | input | 1 | Host control strobe |
| ctl_abort_arm | input | 1 | With ctl_wr: arm the abort tag for the next byte |
| ctl_irq_clr | input | 1 | With ctl_wr: clear the interrupt |
| rd_en | input | 1 | Framer pop |
| rd_valid | output | 1 | Pop of the previous cycle returned an entry |
| rd_none | output | 1 | Pop of the previous cycle found the buffer empty |
| rd_data | output | 8 | Popped byte |
| rd_eop | output | 1 | Popped end-of-packet tag |
| rd_abort | output | 1 | Popped abort tag |
| stat_level | output | 5 | Lagged fill level |
| stat_full | output | 1 | Lagged view equals 19 |
| stat_empty | output | 1 | Lagged view equals 0 |
| stat_low | output | 1 | Lagged view at or below 4 |
| irq | output | 1 | Held low-water interrupt |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| abort_armed | output | 1 | Abort tag armed for the next byte |

## Verification
The two functions that can land on one edge are a host write and a framer pop. The harder cases are a write that meets a full buffer while a pop frees a slot, and a pop that meets an empty buffer while a write fills it. Directed phases drive both strobes together at occupancy 0, 19 and in between, and a random phase mixes them with arm strobes, interrupt clears and bit ticks. On every clock a queue-based model gives the expected pop result, view, flags and interrupt, so a wrong choice of which side wins shows up as a mismatch in that same cycle.

// File: rtl/txf_pkg.sv
// Package: shared entry layout for the tagged transmit FIFO.
// Assumes an 8-bit payload; the two tags ride beside the byte.
package txf_pkg;
    parameter int unsigned TXF_DW = 8;

    typedef struct packed {
        logic              abort;
        logic              eop;
        logic [TXF_DW-1:0] data;
    } txf_entry_t;
endpackage

// File: rtl/txf_store.sv
// Storage ring: DEPTH entries, wrap-around pointers and true occupancy.
// Assumes push/pop are already qualified (no push when full, no pop when
// empty). The read side shows the head entry combinationally.
module txf_store
    import txf_pkg::*;
#(
    parameter int unsigned DEPTH = 19
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           pop,
    input  txf_entry_t                     wentry,
    output txf_entry_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]     occ
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned OW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    txf_entry_t        mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [OW-1:0]     count;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Entry array: cleared on reset, written at the tail on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (push) begin
            mem[wr_ptr] <= wentry;
        end
    end

    // Pointers and occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];
    assign occ  = count;
endmodule

// File: rtl/txf_lag.sv
// Lagged status view: after any accepted access a countdown of LAG_TICKS
// serial bit ticks restarts; the view copies the true occupancy only when
// the countdown expires. Assumes bit_tick is a single-cycle pulse.
module txf_lag #(
    parameter int unsigned DEPTH     = 19,
    parameter int unsigned LAG_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       access,
    input  logic                       bit_tick,
    input  logic [$clog2(DEPTH+1)-1:0] occ,
    output logic [$clog2(DEPTH+1)-1:0] view,
    output logic                       view_upd
);
    localparam int unsigned OW = $clog2(DEPTH + 1);
    localparam int unsigned CW = $clog2(LAG_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(LAG_TICKS);

    logic [CW-1:0] left;
    logic [OW-1:0] view_q;

    // Load strobe: last pending tick arrives with no new access.
    assign view_upd = !access && bit_tick && (left == CW'(1));

    // Countdown restarted by every access, stepped by bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                    left <= '0;
        else if (access)               left <= LOAD;
        else if (bit_tick && left != 0) left <= left - 1'b1;
    end

    // View register: copies occupancy only on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        view_q <= '0;
        else if (view_upd) view_q <= occ;
    end

    assign view = view_q;
endmodule

// File: rtl/txf_irq.sv
// Low-water interrupt: set when the lagged view is loaded with THRESH
// from another value, held until a host clear; a set beats a clear.
module txf_irq #(
    parameter int unsigned OW     = 5,
    parameter int unsigned THRESH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          view_upd,
    input  logic [OW-1:0] new_level,
    input  logic [OW-1:0] cur_level,
    input  logic          clr,
    output logic          irq
);
    localparam logic [OW-1:0] THR = OW'(THRESH);

    logic hit;
    logic irq_q;

    // Arrival at the mark, not residence at it.
    assign hit = view_upd && (new_level == THR) && (cur_level != THR);

    // Held interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_q <= 1'b0;
        else if (hit) irq_q <= 1'b1;
        else if (clr) irq_q <= 1'b0;
    end

    assign irq = irq_q;
endmodule

// File: rtl/tx_tag_fifo.sv
// Tagged transmit FIFO top: qualifies host writes and framer pops, owns
// the self-clearing abort arm, the sticky overflow flag and the registered
// pop result. Assumes one clock domain; serial timing enters via bit_tick.
module tx_tag_fifo
    import txf_pkg::*;
#(
    parameter int unsigned DEPTH     = 19,
    parameter int unsigned THRESH    = 4,
    parameter int unsigned LAG_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_tick,
    input  logic                       wr_en,
    input  logic [TXF_DW-1:0]          wr_data,
    input  logic                       wr_eop,
    input  logic                       ctl_wr,
    input  logic                       ctl_abort_arm,
    input  logic                       ctl_irq_clr,
    input  logic                       rd_en,
    output logic                       rd_valid,
    output logic                       rd_none,
    output logic [TXF_DW-1:0]          rd_data,
    output logic                       rd_eop,
    output logic                       rd_abort,
    output logic [$clog2(DEPTH+1)-1:0] stat_level,
    output logic                       stat_full,
    output logic                       stat_empty,
    output logic                       stat_low,
    output logic                       irq,
    output logic                       ovf_flag,
    output logic                       abort_armed
);
    localparam int unsigned OW = $clog2(DEPTH + 1);
    localparam logic [OW-1:0] FULL_C = OW'(DEPTH);
    localparam logic [OW-1:0] THR_C  = OW'(THRESH);

    logic [OW-1:0] occ;
    logic [OW-1:0] view;
    logic          view_upd;
    logic          push_ok;
    logic          pop_ok;
    logic          armed_q;
    logic          ovf_q;
    txf_entry_t    wentry;
    txf_entry_t    head;
    txf_entry_t    rd_q;
    logic          rv_q;
    logic          rn_q;

    // Accept decisions use the true occupancy, not the lagged view.
    assign push_ok = wr_en && (occ != FULL_C);
    assign pop_ok  = rd_en && (occ != '0);

    assign wentry = '{abort: armed_q, eop: wr_eop, data: wr_data};

    txf_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push_ok),
        .pop    (pop_ok),
        .wentry (wentry),
        .head   (head),
        .occ    (occ)
    );

    txf_lag #(.DEPTH(DEPTH), .LAG_TICKS(LAG_TICKS)) u_lag (
        .clk      (clk),
        .rst_n    (rst_n),
        .access   (push_ok || pop_ok),
        .bit_tick (bit_tick),
        .occ      (occ),
        .view     (view),
        .view_upd (view_upd)
    );

    txf_irq #(.OW(OW), .THRESH(THRESH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .view_upd  (view_upd),
        .new_level (occ),
        .cur_level (view),
        .clr       (ctl_wr && ctl_irq_clr),
        .irq       (irq)
    );

    // Abort arm: consumed by an accepted write, re-armed by the control strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                         armed_q <= 1'b0;
        else if (ctl_wr && ctl_abort_arm)   armed_q <= 1'b1;
        else if (push_ok)                   armed_q <= 1'b0;
    end

    // Sticky overflow on a write that meets a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf_q <= 1'b0;
        else if (wr_en && !push_ok) ovf_q <= 1'b1;
    end

    // Registered pop result; data holds between pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            rv_q <= 1'b0;
            rn_q <= 1'b0;
        end else begin
            rv_q <= pop_ok;
            rn_q <= rd_en && !pop_ok;
            if (pop_ok) rd_q <= head;
        end
    end

    assign rd_valid    = rv_q;
    assign rd_none     = rn_q;
    assign rd_data     = rd_q.data;
    assign rd_eop      = rd_q.eop;
    assign rd_abort    = rd_q.abort;
    assign stat_level  = view;
    assign stat_full   = (view == FULL_C);
    assign stat_empty  = (view == '0);
    assign stat_low    = (view <= THR_C);
    assign ovf_flag    = ovf_q;
    assign abort_armed = armed_q;
endmodule

// File: rtl/tx_tag_fifo_chk.sv
// Checker for tx_tag_fifo: temporal properties on ports and occupancy.
module tx_tag_fifo_chk #(
    parameter int unsigned DEPTH = 19
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bit_tick,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic                       ctl_wr,
    input logic                       ctl_abort_arm,
    input logic                       ctl_irq_clr,
    input logic                       rd_valid,
    input logic                       rd_none,
    input logic [$clog2(DEPTH+1)-1:0] stat_level,
    input logic                       stat_full,
    input logic                       stat_empty,
    input logic                       irq,
    input logic                       ovf_flag,
    input logic                       abort_armed,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int unsigned OW = $clog2(DEPTH + 1);
    localparam logic [OW-1:0] FULL_C = OW'(DEPTH);

    a_r1_ovf_on_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && occ == FULL_C) |=> ovf_flag);

    a_r1_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    a_r1_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_C);

    a_r3_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_armed && wr_en && occ != FULL_C && !(ctl_wr && ctl_abort_arm))
        |=> !abort_armed);

    a_r4_no_tick_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(stat_level));

    a_r4_access_holds_view: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en && occ != FULL_C) || (rd_en && occ != '0)) |=> $stable(stat_level));

    a_r5_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_full && stat_empty));

    a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(ctl_wr && ctl_irq_clr)) |=> irq);

    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && occ == '0) |=> (rd_none && !rd_valid));

    a_r7_result_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, rd_none}));
endmodule

bind tx_tag_fifo tx_tag_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .ctl_wr        (ctl_wr),
    .ctl_abort_arm (ctl_abort_arm),
    .ctl_irq_clr   (ctl_irq_clr),
    .rd_valid      (rd_valid),
    .rd_none       (rd_none),
    .stat_level    (stat_level),
    .stat_full     (stat_full),
    .stat_empty    (stat_empty),
    .irq           (irq),
    .ovf_flag      (ovf_flag),
    .abort_armed   (abort_armed),
    .occ           (occ)
);

// File: tb/tx_tag_fifo_test.sv
`timescale 1ns/1ps
module tx_tag_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick;
    logic       wr_en, wr_eop, ctl_wr, ctl_abort_arm, ctl_irq_clr, rd_en;
    logic [7:0] wr_data;
    logic       rd_valid, rd_none, rd_eop, rd_abort;
    logic [7:0] rd_data;
    logic [4:0] stat_level;
    logic       stat_full, stat_empty, stat_low, irq, ovf_flag, abort_armed;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    // Tick generator control
    int tick_div = 0;   // 0 = no ticks, else period in cycles
    int tick_cnt = 0;

    tx_tag_fifo uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
        .ctl_wr(ctl_wr), .ctl_abort_arm(ctl_abort_arm), .ctl_irq_clr(ctl_irq_clr),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_none(rd_none),
        .rd_data(rd_data), .rd_eop(rd_eop), .rd_abort(rd_abort),
        .stat_level(stat_level), .stat_full(stat_full), .stat_empty(stat_empty),
        .stat_low(stat_low), .irq(irq), .ovf_flag(ovf_flag), .abort_armed(abort_armed)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    logic [9:0] q[$];
    int   m_lag = 0, m_view = 0;
    bit   m_irq = 0, m_ovf = 0, m_arm = 0, m_rv = 0, m_rn = 0;
    logic [9:0] m_rd = '0;

    // Behavioural model advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_lag = 0; m_view = 0; m_irq = 0; m_ovf = 0; m_arm = 0;
            m_rv = 0; m_rn = 0; m_rd = '0;
        end else begin
            int  occ0;
            bit  push, pop, set;
            occ0 = q.size();
            push = wr_en && occ0 < 19;
            pop  = rd_en && occ0 > 0;
            set  = 0;
            m_rv = pop;
            m_rn = rd_en && !pop;
            if (pop) m_rd = q.pop_front();
            if (push) begin
                q.push_back({m_arm, wr_eop, wr_data});
                m_arm = 0;
            end else if (wr_en) m_ovf = 1;
            if (ctl_wr && ctl_abort_arm) m_arm = 1;
            if (push || pop) m_lag = 2;
            else if (bit_tick && m_lag > 0) begin
                m_lag--;
                if (m_lag == 0) begin
                    if (q.size() == 4 && m_view != 4) set = 1;
                    m_view = q.size();
                end
            end
            if (set) m_irq = 1;
            else if (ctl_wr && ctl_irq_clr) m_irq = 0;
        end
    end

    task automatic chk(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    // Compare on the falling edge, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1 && !done) begin
            chk("R2", "rd_valid", int'(rd_valid), int'(m_rv));
            chk("R7", "rd_none", int'(rd_none), int'(m_rn));
            if (m_rv) begin
                chk("R2", "rd_data", int'(rd_data), int'(m_rd[7:0]));
                chk("R2", "rd_eop", int'(rd_eop), int'(m_rd[8]));
                chk("R3", "rd_abort", int'(rd_abort), int'(m_rd[9]));
            end
            chk("R4", "stat_level", int'(stat_level), m_view);
            chk("R5", "stat_full", int'(stat_full), int'(m_view == 19));
            chk("R5", "stat_empty", int'(stat_empty), int'(m_view == 0));
            chk("R5", "stat_low", int'(stat_low), int'(m_view <= 4));
            chk("R6", "irq", int'(irq), int'(m_irq));
            chk("R1", "ovf_flag", int'(ovf_flag), int'(m_ovf));
            chk("R3", "abort_armed", int'(abort_armed), int'(m_arm));
        end
        if (cyc > 150000 && !done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Bit tick generator
    always @(posedge clk) begin
        #1;
        if (tick_div == 0) begin
            bit_tick = 1'b0;
            tick_cnt = 0;
        end else begin
            tick_cnt++;
            bit_tick = (tick_cnt % tick_div) == 0;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; ctl_wr = 0; ctl_abort_arm = 0; ctl_irq_clr = 0;
    endtask

    task automatic wr(input logic [7:0] d, input logic e);
        wr_en = 1; wr_data = d; wr_eop = e;
        step();
        wr_en = 0;
    endtask

    task automatic pop();
        rd_en = 1;
        step();
        rd_en = 0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        rst_n = 0; bit_tick = 0; wr_data = 0; wr_eop = 0;
        idle();
        wait_n(3);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "reset level", int'(stat_level), 0);
        chk("R9", "reset empty", int'(stat_empty), 1);
        chk("R9", "reset irq/ovf/arm", int'({irq, ovf_flag, abort_armed, rd_valid}), 0);
        step();

        // R4: no ticks, view must stay at 0 after writes
        tick_div = 0;
        for (int i = 0; i < 5; i++) wr(8'h10 + 8'(i), i == 4);
        wait_n(6);
        @(negedge clk);
        chk("R4", "level frozen without ticks", int'(stat_level), 0);
        step();
        tick_div = 3;
        wait_n(10);
        @(negedge clk);
        chk("R4", "level after two ticks", int'(stat_level), 5);
        step();

        // R1: fill beyond capacity
        for (int i = 0; i < 16; i++) wr(8'h20 + 8'(i), 0);
        wait_n(10);
        @(negedge clk);
        chk("R1", "full flag at 19", int'(stat_full), 1);
        step();
        // R8 at full: write dropped even with pop
        wr_en = 1; wr_data = 8'hEE; rd_en = 1; step(); idle();
        wr(8'hEF, 0);
        @(negedge clk);
        chk("R1", "overflow flag", int'(ovf_flag), 1);
        step();

        // R6: drain slowly through the mark
        tick_div = 2;
        for (int i = 0; i < 19; i++) begin
            pop();
            wait_n(8);
        end
        @(negedge clk);
        chk("R6", "irq set on drain", int'(irq), 1);
        step();
        ctl_wr = 1; ctl_irq_clr = 1; step(); idle();
        @(negedge clk);
        chk("R6", "irq cleared", int'(irq), 0);
        step();

        // R7: pop while empty, then push+pop together while empty
        pop();
        rd_en = 1; wr_en = 1; wr_data = 8'h55; wr_eop = 1; step(); idle();
        pop();
        wait_n(4);

        // R3: arm, write, arm with write, write
        ctl_wr = 1; ctl_abort_arm = 1; step(); idle();
        wr(8'hA1, 0);
        ctl_wr = 1; ctl_abort_arm = 1; wr_en = 1; wr_data = 8'hA2; wr_eop = 0; step(); idle();
        wr(8'hA3, 1);
        wr(8'hA4, 0);
        for (int i = 0; i < 4; i++) pop();
        wait_n(8);

        // R8: simultaneous push/pop mid-level
        for (int i = 0; i < 6; i++) wr(8'h60 + 8'(i), 0);
        for (int i = 0; i < 10; i++) begin
            wr_en = 1; rd_en = 1; wr_data = 8'h70 + 8'(i); wr_eop = i[0]; step();
        end
        idle();
        wait_n(8);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom % 3) != 0;
            rd_en = ($urandom % 3) != 0 && (i % 400) > 150;
            wr_data = 8'($urandom);
            wr_eop = $urandom % 2;
            ctl_wr = ($urandom % 10) == 0;
            ctl_abort_arm = $urandom % 2;
            ctl_irq_clr = $urandom % 2;
            if (i % 500 == 0) tick_div = 1 + ($urandom % 4);
            step();
        end
        idle();
        wait_n(10);

        // R9: reset mid-stream
        for (int i = 0; i < 7; i++) wr(8'h90, 0);
        ctl_wr = 1; ctl_abort_arm = 1; step(); idle();
        rst_n = 0; step(); rst_n = 1;
        @(negedge clk);
        chk("R9", "reset clears armed", int'(abort_armed), 0);
        chk("R9", "reset clears ovf", int'(ovf_flag), 0);
        step();
        pop();
        @(negedge clk);
        chk("R9", "reset empties buffer", int'(rd_none), 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule